// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Pulse Measurement

This block is a down-counting timer made of two stages. A prescaler stage counts down once for each pulse on a count-source enable input. A main stage counts down once each time the prescaler wraps. Software programs the block over a byte-wide register bus with four addresses. When either stage passes zero it reloads from its own reload register. Each time the main stage wraps, the block sets a sticky underflow flag and raises a one-cycle interrupt.

The block has three operating modes. In plain timer mode it counts freely. In pulse width mode counting is gated by the level of an external measurement input. In pulse period mode the block flags each active edge on that input while it keeps counting.

Starting and stopping follow a handshake. Software writes a start request bit. A read-only status bit copies that request only on the next count-source pulse. Both flags are sticky: writing 0 clears a flag, and writing 1 leaves it unchanged.

Register map:
- Address 0, control:
  - bit 0: start request (read/write)
  - bit 1: running status (read only)
  - bit 2: edge flag
  - bit 3: underflow flag
- Address 1, mode:
  - bits 1:0 select the mode: 0 = timer, 1 = width, 2 = period, 3 = timer
  - bit 2 = 1 makes a high level the active level
- Address 2: prescaler. A write sets the reload value; a read returns the live count.
- Address 3: main counter. A write sets the reload value; a read returns the live count.

Top module: `pulse_timer`

## Requirements
- R1: After reset, every register reads 0, the running status is 0 and irq is low.
- R2: When the start request is set while stopped, the running status becomes 1 on the next count-source pulse, and that pulse does not decrement the prescaler.
- R3: When the start request is cleared while running, the status reads 1 until the next count-source pulse and then reads 0, and no decrement happens after the request is cleared.
- R4: The prescaler decrements on each counting pulse and reloads at zero; the main counter decrements on each prescaler wrap and reloads at zero (prescaler reload P and counter reload C give a main wrap every (P+1)*(C+1) pulses).
- R5: A main counter wrap sets the underflow flag (control bit 3) and drives irq high for exactly one clock cycle.
- R6: The edge flag (bit 2) and the underflow flag (bit 3) clear only when a control write carries 0 in that bit; a write of 1 leaves the flag unchanged.
- R7: While the block is stopped, a write to address 2 or 3 loads both the reload register and the live count. While it is running, such a write changes only the reload register.
- R8: In width mode (mode 1), the stages count only while the synchronized input is at the active level. The edge flag is set when the active level ends, and it is not set when the active level begins.
- R9: In period mode (mode 2), the edge flag is set on each transition into the active level, and both stages count regardless of the input.
- R10: In period mode, the first prescaler wrap after a start sets the edge flag, even when the input shows no edge. Later wraps do not set it.
- R11: The measurement input passes through a two-flop synchronizer, so its effect appears within three clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-source enable, one-cycle pulse per count step |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| meas_in | input | 1 | External measurement input (asynchronous) |
| irq | output | 1 | One-cycle interrupt on main counter wrap |

## Verification
A wrong running status or start latch shows up within one count-source pulse. It appears either as a status bit that reads wrong or as a live count that moves one pulse early or late. A corrupted stage count or reload value shows up at the next readback of address 2 or 3. It also shifts the cycle on which irq pulses, which can be many pulses later for large reload values, so the bench uses small reloads. A wrong edge-detection or synchronizer state appears in the edge flag within three clock cycles of an input change.

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          meas_in,
  output logic          irq
);
  localparam logic [1:0] M_WIDTH  = 2'd1;
  localparam logic [1:0] M_PERIOD = 2'd2;

  logic          start_req, run, first_wrap, edge_f, unf_f, irq_q, act_hi;
  logic [1:0]    mode;
  logic [DW-1:0] pre_rl, pre_q, cnt_rl, cnt_q;
  logic          s1, s2, sd;

  wire act_now  = act_hi ? s2 : ~s2;
  wire act_prev = act_hi ? sd : ~sd;
  wire gate     = (mode != M_WIDTH) | act_now;
  wire step     = cnt_en & run & start_req & gate;
  wire pre_wrap = step & (pre_q == '0);
  wire cnt_wrap = pre_wrap & (cnt_q == '0);

  wire wr_ctrl = bus_wr & (bus_addr == 2'd0);
  wire wr_mode = bus_wr & (bus_addr == 2'd1);
  wire wr_pre  = bus_wr & (bus_addr == 2'd2);
  wire wr_cnt  = bus_wr & (bus_addr == 2'd3);

  wire edge_hit = run & (
      ((mode == M_WIDTH)  & act_prev & ~act_now) |
      ((mode == M_PERIOD) & act_now & ~act_prev) |
      ((mode == M_PERIOD) & first_wrap & pre_wrap));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; sd <= 1'b0;
    end else begin
      s1 <= meas_in; s2 <= s1; sd <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_req  <= 1'b0;
      run        <= 1'b0;
      first_wrap <= 1'b0;
      mode       <= 2'd0;
      act_hi     <= 1'b0;
    end else begin
      if (wr_ctrl) start_req <= bus_wdata[0];
      if (wr_mode) begin
        mode   <= bus_wdata[1:0];
        act_hi <= bus_wdata[2];
      end
      if (cnt_en) run <= start_req;
      if (pre_wrap) first_wrap <= 1'b0;
      else if (cnt_en & start_req & ~run) first_wrap <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_rl <= '0; pre_q <= '0;
      cnt_rl <= '0; cnt_q <= '0;
    end else begin
      if (wr_pre) begin
        pre_rl <= bus_wdata;
        if (!run) pre_q <= bus_wdata;
      end else if (step) begin
        pre_q <= pre_wrap ? pre_rl : pre_q - 1'b1;
      end
      if (wr_cnt) begin
        cnt_rl <= bus_wdata;
        if (!run) cnt_q <= bus_wdata;
      end else if (pre_wrap) begin
        cnt_q <= cnt_wrap ? cnt_rl : cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_f <= 1'b0; unf_f <= 1'b0; irq_q <= 1'b0;
    end else begin
      edge_f <= (edge_f & ~(wr_ctrl & ~bus_wdata[2])) | edge_hit;
      unf_f  <= (unf_f  & ~(wr_ctrl & ~bus_wdata[3])) | cnt_wrap;
      irq_q  <= cnt_wrap;
    end
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: bus_rdata[3:0] = {unf_f, edge_f, run, start_req};
      2'd1: bus_rdata[2:0] = {act_hi, mode};
      2'd2: bus_rdata = pre_q;
      default: bus_rdata = cnt_q;
    endcase
  end
endmodule

module pulse_timer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          bus_wr,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          run,
  input logic          unf_f,
  input logic          edge_f,
  input logic          irq,
  input logic [DW-1:0] pre_q
);
  wire wr_ctrl = bus_wr & (bus_addr == 2'd0);
  wire wr_pre  = bus_wr & (bus_addr == 2'd2);

  a_r2_status_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (run != $past(run)) |-> $past(cnt_en));
  a_r5_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> unf_f);
  a_r6_unf_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unf_f) |-> $past(wr_ctrl && !bus_wdata[3]));
  a_r6_edge_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_f) |-> $past(wr_ctrl && !bus_wdata[2]));
  a_r3_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_pre) |=> $stable(pre_q));
endmodule

bind pulse_timer pulse_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .run(run), .unf_f(unf_f),
  .edge_f(edge_f), .irq(irq), .pre_q(pre_q)
);

// File: tb/pulse_timer_bench.sv
module pulse_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       meas_in = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pulse_timer u_pulse_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .meas_in(meas_in), .irq(irq)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check(d, 0, "R1 register after reset");
    end
    check(irq, 0, "R1 irq after reset");
  endtask

  task automatic t_timer;
    logic [7:0] d;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'd2);
    wr(2'd3, 8'd3);
    rd(2'd2, d); check(d, 2, "R7 stopped write loads prescaler");
    rd(2'd3, d); check(d, 3, "R7 stopped write loads counter");
    wr(2'd0, 8'h01);
    rd(2'd0, d); check(d[1], 0, "R2 status before pulse");
    tick(1);
    rd(2'd0, d); check(d[1], 1, "R2 status after pulse");
    rd(2'd2, d); check(d, 2, "R2 start pulse does not count");
    tick(11);
    rd(2'd3, d); check(d, 0, "R4 counter after 11 pulses");
    rd(2'd0, d); check(d[3], 0, "R5 no flag before wrap");
    cnt_en = 1'b1; @(negedge clk); cnt_en = 1'b0;
    check(irq, 1, "R5 irq on wrap");
    @(negedge clk);
    check(irq, 0, "R5 irq one cycle");
    rd(2'd3, d); check(d, 3, "R4 counter reloaded");
    rd(2'd2, d); check(d, 2, "R4 prescaler reloaded");
    rd(2'd0, d); check(d[3], 1, "R5 underflow flag set");
    wr(2'd0, 8'h09);
    rd(2'd0, d); check(d[3], 1, "R6 write 1 keeps flag");
    wr(2'd0, 8'h01);
    rd(2'd0, d); check(d[3], 0, "R6 write 0 clears flag");
    tick(1);
    wr(2'd3, 8'h80);
    rd(2'd3, d); check(d, 3, "R7 running write leaves count");
  endtask

  task automatic t_stop;
    logic [7:0] d, p0, c0;
    wr(2'd0, 8'h00);
    rd(2'd0, d); check(d[1], 1, "R3 status held until pulse");
    rd(2'd2, p0); rd(2'd3, c0);
    tick(1);
    rd(2'd0, d); check(d[1], 0, "R3 status drops at pulse");
    tick(3);
    rd(2'd2, d); check(d, p0, "R3 prescaler frozen");
    rd(2'd3, d); check(d, c0, "R3 counter frozen");
  endtask

  task automatic t_width;
    logic [7:0] d;
    meas_in = 1'b0;
    wr(2'd1, 8'h05);
    wr(2'd2, 8'd0);
    wr(2'd3, 8'd10);
    wr(2'd0, 8'h01);
    tick(1);
    tick(3);
    rd(2'd3, d); check(d, 10, "R8 no count at inactive level");
    meas_in = 1'b1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check(d[2], 0, "R8 no flag at active start");
    tick(4);
    rd(2'd3, d); check(d, 6, "R8 counts at active level");
    meas_in = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd0, d); check(d[2], 0, "R11 flag not before sync delay");
    @(negedge clk);
    rd(2'd0, d); check(d[2], 1, "R8 R11 flag at active end");
    tick(2);
    rd(2'd3, d); check(d, 6, "R8 stops after active end");
    wr(2'd0, 8'h00);
    tick(1);
  endtask

  task automatic t_period;
    logic [7:0] d;
    meas_in = 1'b0;
    wr(2'd1, 8'h06);
    wr(2'd2, 8'd3);
    wr(2'd3, 8'd50);
    wr(2'd0, 8'h01);
    tick(1);
    tick(3);
    rd(2'd0, d); check(d[2], 0, "R10 no flag before first wrap");
    tick(1);
    rd(2'd0, d); check(d[2], 1, "R10 flag at first wrap");
    rd(2'd3, d); check(d, 49, "R9 counts without input");
    wr(2'd0, 8'h01);
    rd(2'd0, d); check(d[2], 0, "R6 edge flag cleared");
    meas_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd0, d); check(d[2], 1, "R9 flag on active edge");
    wr(2'd0, 8'h01);
    meas_in = 1'b0;
    repeat (4) @(negedge clk);
    tick(4);
    rd(2'd0, d); check(d[2], 0, "R10 later wrap no flag");
    rd(2'd3, d); check(d, 48, "R9 second wrap counted");
    wr(2'd0, 8'h00);
    tick(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timer();
    t_stop();
    t_width();
    t_period();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule